// File: doc/BRIEF.md
# Band-to-Band Block Gain Estimator

This block takes one 16x16 block of unsigned samples from the current spectral band, together with the co-located block from the previous band, and produces the least-squares gain that best predicts the current block from the previous one. It also returns the rounded mean of each block. A downstream predictor uses these results to form its estimate of the current band.

Sample pairs stream in under a valid/ready handshake and are kept in a local buffer. The first pass computes the two block sums. A second pass over the buffer accumulates the cross term and the energy of the centred previous-band samples. No divider is used. The energy is normalised onto a 16-bit mantissa, and a reciprocal is refined from a constant seed by four Newton-Raphson steps on one shared 16x16 multiplier. The same multiplier then scales the normalised cross term by that reciprocal to give an 8-bit gain code. A one-cycle done pulse marks new results, and the results hold until the next pulse.

Top module: `band_gain_est`

## Requirements
- R1: `mean_cur_o` equals (sum of the 256 current samples + 128) >> 8, and `mean_prev_o` follows the same rule for the previous-band samples.
- R2: Let P = prev - mean_prev and C = cur - mean_cur, taken per sample. Define N as the sum over the block of P*C and D as the sum of P*P. When 0 < N < 2*D, `gain_o` is an unsigned code with 1 integer and 7 fraction bits (gain = code/128), and it lies within one step of floor(128*N/D).
- R3: When N >= 2*D and D > 0, including the exact gain of 2, `gain_o` is 255.
- R4: When N <= 0 and D > 0 (zero or negative correlation), `gain_o` is 0.
- R5: When D = 0 (a flat previous block), `gain_o` is 0 and no reciprocal steps are run.
- R6: `done_o` rises exactly 267 cycles after the clock edge that accepts the 256th sample when the reciprocal runs. It rises 258 cycles after that edge in the R3, R4 and R5 cases.
- R7: `done_o` is a single-cycle pulse. `gain_o`, `mean_cur_o` and `mean_prev_o` change only on the edge that raises `done_o`, and they hold while the next block loads.
- R8: `in_ready_o` is high only while a block is being collected, and it returns high in the cycle after `done_o`. Data offered while `in_ready_o` is low has no effect on any later result.
- R9: Cycles with `in_valid_i` low between samples do not change the results, whatever values are on the data inputs.
- R10: While reset is held, all outputs are 0 and `in_ready_o` is 1. A partially loaded block is discarded by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair offered |
| in_ready_o | output | 1 | Block accepts a sample pair |
| cur_i | input | 16 | Current-band sample |
| prev_i | input | 16 | Co-located previous-band sample |
| done_o | output | 1 | One-cycle pulse: results updated |
| mean_cur_o | output | 16 | Rounded mean of current block |
| mean_prev_o | output | 16 | Rounded mean of previous block |
| gain_o | output | 8 | Quantised gain code, value/128 |

## Verification
The hardest situation to reach is the exact gain of 2. There N equals 2*D exactly, so only the comparison decides between the clamp path and the reciprocal path. The bench reaches it with a previous block that ramps in even steps, which gives an integer mean, and with a current block that is exactly twice the previous one; that one block must then show code 255 with the short latency. A second hard case is a previous block that wraps to large values. This pushes D toward the top of the accumulator and exercises the largest normalisation shifts. The other hard case is the traffic that arrives while the block is busy: junk pairs are driven with valid high for the whole processing time, and the next block's means and gain must still match exactly.

// File: rtl/gain_pkg.sv
package gain_pkg;
  localparam int GE_MUL_W = 16;  // multiplier operand width
  localparam int GE_XF    = 14;  // reciprocal fraction bits

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_MEAN,
    ST_CENT,
    ST_NORM,
    ST_NR,
    ST_DONE
  } gest_state_e;
endpackage

// File: rtl/gain_pair_buf.sv
module gain_pair_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 256
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/gain_xsum.sv
module gain_xsum #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 42
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [SAMP_W-1:0]       cur_i,
  input  logic [SAMP_W-1:0]       prev_i,
  input  logic [SAMP_W-1:0]       mean_cur_i,
  input  logic [SAMP_W-1:0]       mean_prev_i,
  output logic signed [ACC_W-1:0] num_o,
  output logic signed [ACC_W-1:0] den_o
);
  localparam int D_W = SAMP_W + 1;
  localparam int P_W = 2 * D_W;

  logic signed [D_W-1:0]   dp, dc;
  logic signed [P_W-1:0]   pc, pp;
  logic signed [ACC_W-1:0] pc_x, pp_x;

  // centred previous value feeds both products
  assign dp   = $signed({1'b0, prev_i}) - $signed({1'b0, mean_prev_i});
  assign dc   = $signed({1'b0, cur_i})  - $signed({1'b0, mean_cur_i});
  assign pc   = dp * dc;
  assign pp   = dp * dp;
  assign pc_x = $signed({{(ACC_W-P_W){pc[P_W-1]}}, pc});
  assign pp_x = $signed({{(ACC_W-P_W){pp[P_W-1]}}, pp});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= '0;
      den_o <= '0;
    end else if (clr_i) begin
      num_o <= '0;
      den_o <= '0;
    end else if (en_i) begin
      num_o <= num_o + pc_x;
      den_o <= den_o + pp_x;
    end
  end
endmodule

// File: rtl/gain_nr_unit.sv
module gain_nr_unit import gain_pkg::*; #(
  parameter int GAIN_W   = 8,
  parameter int NR_STEPS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [GE_MUL_W-1:0] m_i,
  input  logic [GE_MUL_W-1:0] n_i,
  output logic                fin_o,
  output logic [GAIN_W-1:0]   code_o
);
  localparam int MW    = GE_MUL_W;
  localparam int XF    = GE_XF;
  localparam int GF    = GAIN_W - 1;
  localparam int LAST  = 2 * NR_STEPS;
  localparam int CNT_W = $clog2(LAST + 2);
  localparam int Q_SH  = XF + MW - 1 - GF;
  localparam logic [MW-1:0] SEED = MW'(3 << (XF - 1));  // 1.5
  localparam logic [MW-1:0] TWO  = MW'(1 << (XF + 1));

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MW-1:0]    x_q, t_q, m_q, n_q;
  logic [MW-1:0]    op_a;
  logic [2*MW-1:0]  prod, qv;
  logic             quant;

  assign quant = act_q && (cnt_q == CNT_W'(LAST));

  // one multiplier: m*x, then x*t per step, then n*x
  always_comb begin
    if (quant)         op_a = n_q;
    else if (cnt_q[0]) op_a = t_q;
    else               op_a = m_q;
    prod = op_a * x_q;
    qv   = prod >> Q_SH;
  end

  assign fin_o  = quant;
  assign code_o = (qv > (2*MW)'((1 << GAIN_W) - 1)) ? '1 : qv[GAIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      x_q   <= '0;
      t_q   <= '0;
      m_q   <= '0;
      n_q   <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      x_q   <= SEED;
      m_q   <= m_i;
      n_q   <= n_i;
    end else if (act_q) begin
      if (quant) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (!cnt_q[0]) t_q <= TWO - prod[2*MW-1:MW];
        else           x_q <= prod[XF+MW-1:XF];
      end
    end
  end
endmodule

// File: rtl/band_gain_est.sv
module band_gain_est import gain_pkg::*; #(
  parameter int SAMP_W   = 16,
  parameter int BLK_N    = 256,
  parameter int ACC_W    = 42,
  parameter int NR_STEPS = 4,
  parameter int GAIN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [SAMP_W-1:0] cur_i,
  input  logic [SAMP_W-1:0] prev_i,
  output logic              done_o,
  output logic [SAMP_W-1:0] mean_cur_o,
  output logic [SAMP_W-1:0] mean_prev_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int LOGN  = $clog2(BLK_N);
  localparam int SUM_W = SAMP_W + LOGN;
  localparam int MW    = GE_MUL_W;
  localparam int SH_W  = $clog2(ACC_W + MW);
  localparam logic [LOGN-1:0] LAST = LOGN'(BLK_N - 1);

  gest_state_e       state_q;
  logic [LOGN-1:0]   idx_q;
  logic [SUM_W-1:0]  sum_c_q, sum_p_q;
  logic [SAMP_W-1:0] mean_c_q, mean_p_q;
  logic [SUM_W:0]    rnd_c, rnd_p;

  logic [2*SAMP_W-1:0]     rd_pair;
  logic signed [ACC_W-1:0] num, den;
  logic [ACC_W-1:0]        num_u, den_u, den_al, num_al;
  logic [SH_W-1:0]         msb_h;
  logic                    num_pos, den_zero, full, skip;
  logic                    nr_fin;
  logic [GAIN_W-1:0]       nr_code;

  assign in_ready_o = (state_q == ST_LOAD);
  assign done_o     = (state_q == ST_DONE);

  gain_pair_buf #(.W(2*SAMP_W), .DEPTH(BLK_N)) u_buf (
    .clk_i   (clk_i),
    .we_i    (in_ready_o && in_valid_i),
    .waddr_i (idx_q),
    .wdata_i ({prev_i, cur_i}),
    .raddr_i (idx_q),
    .rdata_o (rd_pair)
  );

  gain_xsum #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_xsum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_MEAN),
    .en_i        (state_q == ST_CENT),
    .cur_i       (rd_pair[SAMP_W-1:0]),
    .prev_i      (rd_pair[2*SAMP_W-1:SAMP_W]),
    .mean_cur_i  (mean_c_q),
    .mean_prev_i (mean_p_q),
    .num_o       (num),
    .den_o       (den)
  );

  // rounded means
  assign rnd_c = {1'b0, sum_c_q} + (SUM_W+1)'(BLK_N / 2);
  assign rnd_p = {1'b0, sum_p_q} + (SUM_W+1)'(BLK_N / 2);

  // normalise D to a mantissa in [0.5,1) and N one bit lower
  assign num_u = num;
  assign den_u = den;

  always_comb begin
    msb_h = '0;
    for (int b = 0; b < ACC_W; b++) begin
      if (den_u[b]) msb_h = SH_W'(b);
    end
  end

  always_comb begin
    if (msb_h >= SH_W'(MW - 1)) den_al = den_u >> (msb_h - SH_W'(MW - 1));
    else                        den_al = den_u << (SH_W'(MW - 1) - msb_h);
    if (msb_h >= SH_W'(MW - 2)) num_al = num_u >> (msb_h - SH_W'(MW - 2));
    else                        num_al = num_u << (SH_W'(MW - 2) - msb_h);
  end

  assign den_zero = (den_u == '0);
  assign num_pos  = !num[ACC_W-1] && (num_u != '0);
  assign full     = num_pos && ({1'b0, num_u} >= {den_u, 1'b0});
  assign skip     = den_zero || !num_pos || full;

  gain_nr_unit #(.GAIN_W(GAIN_W), .NR_STEPS(NR_STEPS)) u_nr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i ((state_q == ST_NORM) && !skip),
    .m_i     (den_al[MW-1:0]),
    .n_i     (num_al[MW-1:0]),
    .fin_o   (nr_fin),
    .code_o  (nr_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_LOAD;
      idx_q       <= '0;
      sum_c_q     <= '0;
      sum_p_q     <= '0;
      mean_c_q    <= '0;
      mean_p_q    <= '0;
      mean_cur_o  <= '0;
      mean_prev_o <= '0;
      gain_o      <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: if (in_valid_i) begin
          sum_c_q <= sum_c_q + SUM_W'(cur_i);
          sum_p_q <= sum_p_q + SUM_W'(prev_i);
          idx_q   <= idx_q + LOGN'(1);
          if (idx_q == LAST) state_q <= ST_MEAN;
        end
        ST_MEAN: begin
          mean_c_q <= rnd_c[SUM_W-1:LOGN];
          mean_p_q <= rnd_p[SUM_W-1:LOGN];
          sum_c_q  <= '0;
          sum_p_q  <= '0;
          idx_q    <= '0;
          state_q  <= ST_CENT;
        end
        ST_CENT: begin
          idx_q <= idx_q + LOGN'(1);
          if (idx_q == LAST) state_q <= ST_NORM;
        end
        ST_NORM: begin
          if (skip) begin
            gain_o      <= full ? '1 : '0;
            mean_cur_o  <= mean_c_q;
            mean_prev_o <= mean_p_q;
            state_q     <= ST_DONE;
          end else begin
            state_q <= ST_NR;
          end
        end
        ST_NR: if (nr_fin) begin
          gain_o      <= nr_code;
          mean_cur_o  <= mean_c_q;
          mean_prev_o <= mean_p_q;
          state_q     <= ST_DONE;
        end
        ST_DONE: begin
          idx_q   <= '0;
          state_q <= ST_LOAD;
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/band_gain_est_chk.sv
module band_gain_est_chk #(
  parameter int SAMP_W   = 16,
  parameter int BLK_N    = 256,
  parameter int NR_STEPS = 4,
  parameter int GAIN_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              done_o,
  input logic [SAMP_W-1:0] mean_cur_o,
  input logic [SAMP_W-1:0] mean_prev_o,
  input logic [GAIN_W-1:0] gain_o
);
  localparam int LAT_SKIP = BLK_N + 2;
  localparam int LAT_FULL = BLK_N + 3 + 2 * NR_STEPS;

  logic [$clog2(BLK_N+1)-1:0] acc_q;
  logic [15:0]                tmr_q;
  logic                       run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      tmr_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        if (acc_q == ($clog2(BLK_N+1))'(BLK_N - 1)) begin
          acc_q <= '0;
          run_q <= 1'b1;
          tmr_q <= '0;
        end else begin
          acc_q <= acc_q + 1'b1;
        end
      end else if (run_q) begin
        tmr_q <= tmr_q + 16'd1;
      end
      if (done_o) run_q <= 1'b0;
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(gain_o) && $stable(mean_cur_o) && $stable(mean_prev_o)));

  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !in_ready_o);

  a_r8_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> in_ready_o);

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q && (tmr_q == 16'(LAT_SKIP) || tmr_q == 16'(LAT_FULL))));
endmodule

bind band_gain_est band_gain_est_chk #(
  .SAMP_W(SAMP_W), .BLK_N(BLK_N), .NR_STEPS(NR_STEPS), .GAIN_W(GAIN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .done_o      (done_o),
  .mean_cur_o  (mean_cur_o),
  .mean_prev_o (mean_prev_o),
  .gain_o      (gain_o)
);

// File: tb/sim_band_gain_est.sv
module sim_band_gain_est;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] cur = '0, prev = '0;
  logic        done;
  logic [15:0] mean_c, mean_p;
  logic [7:0]  gain;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  band_gain_est u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .cur_i(cur), .prev_i(prev), .done_o(done),
    .mean_cur_o(mean_c), .mean_prev_o(mean_p), .gain_o(gain)
  );

  // stimulus vectors: prev_base, prev_step, gain*128, cur_offset, negate, noise_mask
  // expected results are derived from each vector's generated samples
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{1000,    37, 128,     0, 0,   0},  // ~1.0
    '{2000,   150,  64,   300, 0,   0},  // ~0.5
    '{500,     90, 200,     0, 0,   0},  // ~1.56
    '{300,    100, 300,     0, 0,   0},  // >2, clamp
    '{1000,    50, 128, 60000, 1,   0},  // negative
    '{5000,     0, 128,     0, 0, 255},  // flat prev
    '{3000,    20, 100,  1000, 0, 255},  // noisy
    '{40000,   97, 128,     0, 0,   0},  // high values
    '{100,    200,   3,     5, 0,   0},  // tiny gain
    '{0,    30000, 128,     0, 0,  15},  // wrapping, large energy
    '{1000,     2, 256,     0, 0,   0}   // exactly 2
  };

  logic [15:0] pb [256];
  logic [15:0] cb [256];
  longint e_num, e_den;
  int e_mc, e_mp, e_code, e_lat;
  string e_req;
  logic [15:0] h_mc = '0, h_mp = '0;
  logic [7:0]  h_g = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 256; i++) begin
      longint p, t;
      p = (VEC[v][0] + VEC[v][1] * i) & 16'hFFFF;
      t = (p * VEC[v][2]) >>> 7;
      if (VEC[v][4] != 0) t = -t;
      t = t + VEC[v][3] + ((i * 29) & VEC[v][5]);
      if (t < 0) t = 0;
      if (t > 65535) t = 65535;
      pb[i] = 16'(p);
      cb[i] = 16'(t);
    end
  endtask

  task automatic calc();
    longint sc = 0, sp = 0;
    for (int i = 0; i < 256; i++) begin
      sc += cb[i];
      sp += pb[i];
    end
    e_mc = int'((sc + 128) >>> 8);
    e_mp = int'((sp + 128) >>> 8);
    e_num = 0;
    e_den = 0;
    for (int i = 0; i < 256; i++) begin
      longint dp, dc;
      dp = longint'(pb[i]) - e_mp;
      dc = longint'(cb[i]) - e_mc;
      e_num += dp * dc;
      e_den += dp * dp;
    end
    if (e_den == 0)             begin e_code = 0;   e_req = "R5"; e_lat = 258; end
    else if (e_num <= 0)        begin e_code = 0;   e_req = "R4"; e_lat = 258; end
    else if (e_num >= 2*e_den)  begin e_code = 255; e_req = "R3"; e_lat = 258; end
    else begin
      e_code = int'((e_num * 128) / e_den);
      e_req = "R2";
      e_lat = 267;
    end
  endtask

  // gap: idle cycles with junk data between samples
  task automatic send(input bit gap, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      prev = pb[i];
      cur  = cb[i];
      if (i == 128) begin
        chk(gain == h_g && mean_c == h_mc && mean_p == h_mp, "R7 hold", gain, h_g);
      end
      @(posedge clk);
      if (gap && i < count - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        prev = 16'hDEAD ^ 16'(i);
        cur  = 16'hBEEF + 16'(i);
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_block(input int v, input bit gap, input bit junk);
    int lat = 0;
    bit rdy_bad = 0;
    fill(v);
    calc();
    send(gap, 256);
    do begin
      if (junk) begin
        in_valid = 1'b1;
        prev = 16'hFFFF - 16'(lat);
        cur  = 16'(lat * 77);
      end
      @(negedge clk);
      lat++;
      if (in_ready) rdy_bad = 1;
    end while (!done && lat < 400);
    in_valid = 1'b0;
    if (junk) chk(!rdy_bad, "R8 ready low while busy", rdy_bad, 0);
    chk(lat == e_lat, "R6 latency", lat, e_lat);
    chk(mean_c == 16'(e_mc), "R1 current mean", mean_c, e_mc);
    chk(mean_p == 16'(e_mp), "R1 previous mean", mean_p, e_mp);
    if (e_req == "R2")
      chk(int'(gain) >= e_code - 1 && int'(gain) <= e_code + 1, "R2 gain", gain, e_code);
    else
      chk(int'(gain) == e_code, {e_req, " gain"}, gain, e_code);
    h_g = gain;
    h_mc = mean_c;
    h_mp = mean_p;
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
    chk(in_ready, "R8 ready after done", in_ready, 1);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL R6 watchdog expired actual=busy expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(gain == 0 && mean_c == 0 && mean_p == 0, "R10 outputs in reset", gain, 0);
    chk(in_ready && !done, "R10 ready in reset", in_ready, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready && !done, "R10 ready after reset", in_ready, 1);

    for (int v = 0; v < NV; v++) run_block(v, 1'b0, 1'b0);

    // R9 stalls with junk data between samples
    run_block(2, 1'b1, 1'b0);
    run_block(6, 1'b1, 1'b0);

    // R8 traffic while busy is ignored; next block still exact
    run_block(0, 1'b0, 1'b1);
    run_block(7, 1'b0, 1'b0);

    // R10 partial block discarded by reset
    fill(9);
    send(1'b0, 100);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(gain == 0 && mean_c == 0 && mean_p == 0, "R10 outputs cleared", gain, 0);
    chk(in_ready, "R10 ready after mid-block reset", in_ready, 1);
    h_g = '0;
    h_mc = '0;
    h_mp = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    run_block(1, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule